// File: doc/BRIEF.md
# Chained Word Forwarding Node

This node sits on a one-way link of 32-bit words that runs through a string of identical nodes. The words of a frame arrive one at a time with a valid strobe. A frame is closed by a separate frame-end strobe. The first words of a frame are a header that every node needs, so the node copies them downstream unchanged. After the header, the node holds each incoming word for one word slot and sends out the word it held before. When the frame ends, the word still held is the frame's final word. The node keeps that word as its own value and does not send it on.

In a chain, the first node therefore keeps the last word of the frame. The next node never sees that word, so it keeps the word before it, and so on down the chain. The host loads per-node values by placing them at the tail of the frame in reverse chain order. The header length is the parameter `PASS` (default 18, at least 1), and the word width is `WIDTH`.

Top module: `chain_word_node`

## Requirements
- R1: After reset, `out_valid`, `out_end` and `cap_valid` are low and `cap_word` is zero.
- R2: Words 0 to PASS-1 of a frame appear on `out_word` with `out_valid` high one clock after they are accepted, unchanged and in order.
- R3: Word PASS of a frame produces no output. Each later word causes the previously received word to be emitted one clock later. `out_valid` is never high unless `in_valid` was high on the clock before.
- R4: When `in_end` is high and a post-header word is held, that word is written to `cap_word` with a single-cycle `cap_valid` pulse one clock later, and it is never forwarded.
- R5: A frame of PASS words or fewer raises no `cap_valid`, and `cap_word` keeps its previous value. `cap_word` changes only in a cycle where `cap_valid` is high.
- R6: `out_end` pulses exactly two clocks after `in_end`, which is strictly after the last word forwarded for that frame.
- R7: `in_end` restarts the word count, so the next frame again passes its first PASS words through.
- R8: With two nodes in series, the second node captures the next-to-last word of a frame, provided the frame has more than PASS+1 words.
- R9: If `in_end` arrives in the same cycle as an accepted word, that word counts as the last word of the frame. When it lies beyond the header, it is the word captured, and the word held before it is still forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream word strobe |
| in_word | input | WIDTH | Upstream word |
| in_end | input | 1 | Upstream frame-end strobe |
| out_valid | output | 1 | Downstream word strobe |
| out_word | output | WIDTH | Downstream word |
| out_end | output | 1 | Downstream frame-end strobe |
| cap_valid | output | 1 | Pulse when a new own value is taken |
| cap_word | output | WIDTH | Own value kept from the frame tail |

## Verification
The hardest case to reach is the frame end arriving in the same cycle as the final word. In that cycle the node must emit its held word and capture the incoming one at the same time. The bench drives this by raising `in_end` alongside the last word of a 20-word frame. It also places frames of exactly PASS and PASS+1 words at the boundary, where either nothing is captured or the second node of a two-node chain receives only a bare header.

// File: rtl/chain_word_node.sv
module chain_word_node #(
  parameter int WIDTH = 32,
  parameter int PASS  = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_word,
  input  logic             in_end,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_word,
  output logic             out_end,
  output logic             cap_valid,
  output logic [WIDTH-1:0] cap_word
);
  localparam int CW = $clog2(PASS + 1);

  logic [CW-1:0]    cnt;
  logic [WIDTH-1:0] hold;
  logic             hold_vld;
  logic             end_q;
  logic             in_prefix;

  assign in_prefix = cnt < CW'(PASS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      hold      <= '0;
      hold_vld  <= 1'b0;
      end_q     <= 1'b0;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_end   <= 1'b0;
      cap_valid <= 1'b0;
      cap_word  <= '0;
    end else begin
      out_valid <= in_valid && (in_prefix || hold_vld);
      if (in_valid)
        out_word <= in_prefix ? in_word : hold;
      end_q     <= in_end;
      out_end   <= end_q;
      cap_valid <= 1'b0;
      if (in_end) begin
        cnt      <= '0;
        hold_vld <= 1'b0;
        if (in_valid && !in_prefix) begin
          cap_word  <= in_word;
          cap_valid <= 1'b1;
        end else if (hold_vld) begin
          cap_word  <= hold;
          cap_valid <= 1'b1;
        end
      end else if (in_valid) begin
        if (in_prefix) begin
          cnt <= cnt + 1'b1;
        end else begin
          hold     <= in_word;
          hold_vld <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/chain_word_node_chk.sv
module chain_word_node_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_end,
  input logic             out_valid,
  input logic             out_end,
  input logic             cap_valid,
  input logic [WIDTH-1:0] cap_word
);
  // R3
  out_from_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R4
  cap_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> $past(in_end));

  // R4
  cap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> !cap_valid);

  // R5
  cap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_valid |-> $stable(cap_word));

  // R6
  end_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_end |-> $past(in_end, 2));
endmodule

bind chain_word_node chain_word_node_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_end(in_end),
  .out_valid(out_valid), .out_end(out_end),
  .cap_valid(cap_valid), .cap_word(cap_word)
);

// File: tb/test_chain_word_node.sv
module test_chain_word_node;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int PASS = 18;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_end = 0;
  logic [W-1:0] in_word = '0;
  logic v1, e1, c1, v2, e2, c2;
  logic [W-1:0] w1, cw1, w2, cw2;

  int checks = 0, errors = 0, cyc = 0;
  logic [W-1:0] q1[$], q2[$], cq1[$], cq2[$];
  int last_out1, end1_cyc, end_drive_cyc;
  logic [W-1:0] exp_cap1 = '0, exp_cap2 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  chain_word_node #(.WIDTH(W), .PASS(PASS)) i_chain_word_node (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word), .in_end(in_end),
    .out_valid(v1), .out_word(w1), .out_end(e1), .cap_valid(c1), .cap_word(cw1));

  chain_word_node #(.WIDTH(W), .PASS(PASS)) i_next (
    .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_word(w1), .in_end(e1),
    .out_valid(v2), .out_word(w2), .out_end(e2), .cap_valid(c2), .cap_word(cw2));

  always @(negedge clk) if (rst_n) begin
    if (v1) begin q1.push_back(w1); last_out1 = cyc; end
    if (e1) end1_cyc = cyc;
    if (c1) cq1.push_back(cw1);
    if (v2) q2.push_back(w2);
    if (c2) cq2.push_back(cw2);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(v1 == 0 && e1 == 0 && c1 == 0, "R1", "strobes", {v1, e1, c1}, 0);
    chk(cw1 == 0, "R1", "cap_word", cw1, 0);
  endtask

  task automatic run_frame(input int n, input logic [W-1:0] base, input bit overlap);
    int m;
    q1.delete(); q2.delete(); cq1.delete(); cq2.delete();
    last_out1 = -1; end1_cyc = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_word = base + W'(i);
      if (overlap && i == n - 1) begin in_end = 1; end_drive_cyc = cyc; end
    end
    @(negedge clk);
    in_valid = 0;
    if (!overlap) begin in_end = 1; end_drive_cyc = cyc; @(negedge clk); end
    in_end = 0;
    repeat (8) @(negedge clk);
    // R2 R3: node 1 forwarding
    m = (n > PASS) ? n - 1 : n;
    chk(q1.size() == m, "R3", "node1 word count", q1.size(), m);
    for (int i = 0; i < m && i < q1.size(); i++)
      chk(q1[i] == base + W'(i), i < PASS ? "R2" : "R3", "node1 word", q1[i], base + W'(i));
    // R4 R5 R9: node 1 capture
    if (n > PASS) exp_cap1 = base + W'(n - 1);
    chk(cq1.size() == (n > PASS ? 1 : 0), n > PASS ? "R4" : "R5", "node1 pulses", cq1.size(), n > PASS);
    chk(cw1 == exp_cap1, overlap ? "R9" : (n > PASS ? "R4" : "R5"), "node1 cap_word", cw1, exp_cap1);
    // R6
    chk(end1_cyc == end_drive_cyc + 2, "R6", "out_end cycle", end1_cyc, end_drive_cyc + 2);
    chk(last_out1 < end1_cyc, "R6", "out_end after last word", last_out1, end1_cyc);
    // R8: second node
    if (m > PASS) exp_cap2 = base + W'(m - 1);
    chk(cq2.size() == (m > PASS ? 1 : 0), "R8", "node2 pulses", cq2.size(), m > PASS);
    chk(cw2 == exp_cap2, "R8", "node2 cap_word", cw2, exp_cap2);
    chk(q2.size() == ((m > PASS) ? m - 1 : m), "R8", "node2 word count", q2.size(), (m > PASS) ? m - 1 : m);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    run_frame(18, 32'h0000_0000, 0);   // R2 R5 header only
    run_frame(22, 32'h0000_0100, 0);   // R3 R4 R6 R8
    run_frame(5,  32'h0000_0200, 0);   // R7 R5 short frame after long
    run_frame(20, 32'h0000_0300, 1);   // R9 end with last word
    run_frame(19, 32'h0000_0400, 0);   // R7 R8 node2 gets header only
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule